// File: doc/BRIEF.md
# Presettable Binary Up-Counter with Cascade Enables

This block is a synchronous binary up-counter of parameterised width, 4 bits by default. It steps through the full modulo-2^WIDTH sequence on rising clock edges. A parallel data word can be preset into the state through an active-low synchronous load. An active-low master reset clears the state at once, without waiting for a clock edge.

Counting is gated by two enables. The parallel enable only gates the increment. The trickle enable gates the increment and also qualifies the terminal-count output. Wider synchronous counters and programmable dividers are built by feeding one stage's terminal count into the enables of the next stage.

Control precedence is fixed: reset first, then load, then count, then hold.

Top module: `sync_preset_counter`

## Requirements
- R1: With load_ni high and both enables high, count_o increments by one on each rising edge, and the all-ones state (15 by default) wraps to 0.
- R2: While rst_ni is low, count_o is 0 immediately, without waiting for a clock edge, whatever the other inputs are.
- R3: When load_ni is low at a rising edge, count_o takes the value of data_i, whatever the enables are.
- R4: With load_ni high, count_o holds its value across a rising edge when en_par_i is low or en_trk_i is low.
- R5: term_o is high exactly when en_trk_i is high and count_o is all ones; en_par_i has no effect on term_o.
- R6: Loading all ones while en_trk_i is high makes term_o high in the following cycle, with no counting edge in between.
- R7: After rst_ni returns high, counting resumes from 0 on the next enabled edge.
- R8: Changes on load_ni, data_i and the enables between rising edges do not alter count_o; only their values at the edge matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | WIDTH | Preset value |
| en_par_i | input | 1 | Parallel count enable |
| en_trk_i | input | 1 | Trickle count enable; also gates term_o |
| count_o | output | WIDTH | Counter state |
| term_o | output | 1 | Terminal count |

## Verification
The bench drives the block against a behavioural reference and targets four cases.

- Wrap from all ones to zero: a counter that saturates or skips there fails.
- Load issued together with both enables high: a design that lets counting win loads the wrong value.
- Terminal count with only the parallel enable low: a design that gates term_o on both enables drops term_o low.
- Reset asserted between clock edges: a synchronous reset leaves stale state visible until the next edge.

The bench also pulses the load input low and back high between edges. A level-sensitive load would corrupt a held value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      load_ni,
  input  logic      en_par_i,
  input  logic      en_trk_i,
  output cnt_mode_e mode_o
);
  // load beats count beats hold
  always_comb begin
    if (!load_ni)                 mode_o = MODE_LOAD;
    else if (en_par_i && en_trk_i) mode_o = MODE_COUNT;
    else                          mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_mode_e        mode_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      unique case (mode_i)
        MODE_LOAD:  q_o <= data_i;
        MODE_COUNT: q_o <= q_o + 1'b1;
        default:    q_o <= q_o;
      endcase
    end
  end

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i inside {MODE_HOLD, MODE_COUNT, MODE_LOAD}); // R4
endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_trk_i,
  output logic             term_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = en_trk_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign chain[i+1] = chain[i] & q_i[i];
  end
  assign term_o = chain[WIDTH];
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_par_i,
  input  logic             en_trk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  cnt_mode_e mode;

  cnt_mode_dec u_mode (
    .load_ni (load_ni),
    .en_par_i(en_par_i),
    .en_trk_i(en_trk_i),
    .mode_o  (mode)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .data_i(data_i),
    .q_o   (count_o)
  );

  cnt_term_dec #(.WIDTH(WIDTH)) u_term (
    .q_i     (count_o),
    .en_trk_i(en_trk_i),
    .term_o  (term_o)
  );

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_par_i && en_trk_i) |=> count_o == $past(count_o) + 1'b1); // R1
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0); // R2
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i)); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(en_par_i && en_trk_i)) |=> $stable(count_o)); // R4
  AST_TERM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o == (en_trk_i && count_o == ALL_ONES)); // R5
endmodule

// File: tb/sim_sync_preset_counter.sv
`timescale 1ns/1ps
module sim_sync_preset_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1;
  logic [W-1:0] data = '0;
  logic par = 1'b0;
  logic trk = 1'b0;
  logic [W-1:0] count;
  logic term;

  int total = 0;
  int bad = 0;
  int model = 0;

  always #10 clk = ~clk;

  sync_preset_counter #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .en_par_i(par), .en_trk_i(trk), .count_o(count), .term_o(term)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model <= 0;
    else if (!load_n) model <= int'(data);
    else if (par && trk) model <= (model + 1) % 16;
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic cmp(input string tag);
    check({tag, " count"}, int'(count), model);
    check("R5 term", int'(term), (trk && model == 15) ? 1 : 0);
  endtask

  // apply inputs after a falling edge, compare at the next falling edge
  task automatic step(input logic ld, input int d, input logic p, input logic t, input string tag);
    load_n = ld; data = W'(d); par = p; trk = t;
    @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R2 reset count", int'(count), 0);
    rst_n = 1'b1;
    // R7: resume from zero
    step(1'b1, 0, 1'b1, 1'b1, "R7");
    check("R7 first after reset", int'(count), 1);
    // R1: run through wrap
    for (int i = 0; i < 20; i++) step(1'b1, 0, 1'b1, 1'b1, "R1");
    check("R1 wrap position", int'(count), 5);
    // R4: hold patterns
    step(1'b1, 0, 1'b0, 1'b1, "R4");
    step(1'b1, 0, 1'b1, 1'b0, "R4");
    step(1'b1, 0, 1'b0, 1'b0, "R4");
    check("R4 held", int'(count), 5);
    // R3: load beats both enables
    step(1'b0, 9, 1'b1, 1'b1, "R3");
    check("R3 load value", int'(count), 9);
    step(1'b0, 2, 1'b0, 1'b0, "R3");
    // R6: load all ones, trickle high, parallel low
    step(1'b0, 15, 1'b0, 1'b1, "R6");
    check("R6 term after load", int'(term), 1);
    check("R6 no count", int'(count), 15);
    // R5: parallel enable irrelevant to term
    par = 1'b1; load_n = 1'b1; trk = 1'b1; #1;
    check("R5 term par high", int'(term), 1);
    par = 1'b0; #1;
    check("R5 term par low", int'(term), 1);
    trk = 1'b0; #1;
    check("R5 term trk low", int'(term), 0);
    step(1'b1, 0, 1'b0, 1'b0, "R5");
    // R1: wrap 15 -> 0
    step(1'b1, 0, 1'b1, 1'b1, "R1");
    check("R1 wrap to zero", int'(count), 0);
    // R8: glitch controls between edges
    load_n = 1'b1; par = 1'b0; trk = 1'b0;
    #3 load_n = 1'b0; data = 4'd7; par = 1'b1; trk = 1'b1;
    #2 load_n = 1'b1; par = 1'b0; trk = 1'b0;
    @(negedge clk);
    cmp("R8");
    check("R8 glitch ignored", int'(count), 0);
    for (int i = 0; i < 6; i++) step(1'b1, 0, 1'b1, 1'b1, "R1");
    // R2: async reset mid-cycle
    #3 rst_n = 1'b0;
    #1 check("R2 async clear", int'(count), 0);
    load_n = 1'b0; data = 4'd11; par = 1'b1; trk = 1'b1;
    @(negedge clk);
    check("R2 overrides load", int'(count), 0);
    rst_n = 1'b1;
    step(1'b1, 0, 1'b1, 1'b1, "R7");
    check("R7 resume", int'(count), 1);
    step(1'b1, 0, 1'b1, 1'b1, "R7");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule